// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block models a byte-wide serial EEPROM that listens on a two-wire bus. Both bus lines are brought into the system clock domain through short synchronizers. Start and stop conditions are found by watching SDA while SCL is high. A device-select byte addresses the part, and the part answers only when the select byte carries its strap level. A write carries a 17-bit word address: the top bit sits in the select byte and two further bytes hold the rest. The data bytes that follow are gathered in a page buffer. They are moved into the array only when a clean stop arrives, and a programming interval then follows during which the part ignores its select byte.

Reads come in three forms. A current-address read uses an internal counter. A random read is a write that stops after the address bytes, followed by a repeated start and a read select. A sequential read continues for as long as the master acknowledges each byte. The line is open-drain: the block only pulls SDA low through `sda_oe`, and the board or bench supplies the pull-up. The word address space is 17 bits wide. The array itself holds `2**STORE_AW` bytes, and each word address maps to the array slot given by its low `STORE_AW` bits. The page size is `2**PAGE_W` bytes.

Top module: `tw_eeprom`

## Requirements
- R1: The select byte is, MSB first, `1010`, `0`, strap level, word-address bit 16, then read(1)/write(0). It is acknowledged only when its upper five bits are `10100` and its strap bit equals `sel_strap`; any other select byte gets no acknowledge.
- R2: After a committing stop, the block acknowledges no select byte until a programming interval of at least `BUSY_CYC` clocks has ended.
- R3: A write takes address bits 15:8, then address bits 7:0, then data bytes, and acknowledges each one. The data is written to the array only by a stop that falls on a byte boundary after at least one data byte.
- R4: In a multi-byte write, the low `PAGE_W` address bits advance after each data byte and wrap to the start of the same page.
- R5: While `wr_protect` is high at the stop, the data bytes are still acknowledged, but the array is left unchanged and no programming interval starts.
- R6: A random read returns the array byte at the word address that the preceding address bytes set.
- R7: A sequential read advances the address after every byte and wraps from 0x1FFFF to 0x00000.
- R8: The address counter holds the location after the last byte accessed. It resets to 0, and a current-address read returns the byte at the counter.
- R9: A stop in the middle of a byte, or a repeated start after data bytes, discards the buffered data without a programming interval, and SDA is released after any stop.
- R10: After reset SDA is released. The block only pulls SDA low, and it starts pulling low only just after a falling SCL edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl | input | 1 | Bus clock from the master |
| sda_in | input | 1 | Level of the shared data line |
| sda_oe | output | 1 | High to pull the data line low |
| wr_protect | input | 1 | High inhibits every array write; tie low if unused |
| sel_strap | input | 1 | Strap level matched against the select byte; tie low if unused |

## Verification
The bench builds the block with `PAGE_W=4`, `STORE_AW=9` and `BUSY_CYC=600`. The 16-byte pages let a short transfer wrap within a page. The 600-clock programming interval is longer than one select byte, so the first acknowledge poll after a commit is always refused and a later poll succeeds. The 512-byte array lets the bench place data at 0x1FFFE and 0x00000 at low cost and read across the top of the address space.

// File: rtl/tw_eeprom_pkg.sv
package tw_eeprom_pkg;
  localparam int WORD_AW = 17;

  typedef enum logic [2:0] {
    PH_IDLE, PH_RX, PH_ACK, PH_ACKH, PH_TX, PH_MACK, PH_MACKF
  } phase_e;

  typedef enum logic [1:0] {
    FLD_SEL, FLD_AHI, FLD_ALO, FLD_DATA
  } field_e;
endpackage

// File: rtl/tw_line_sense.sv
module tw_line_sense #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  input  logic sda,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det,
  output logic sda_s
);
  logic [SYNC_N-1:0] scl_sr, sda_sr;
  logic scl_p, sda_p, scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sr <= '1;
      sda_sr <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_sr <= {scl_sr[SYNC_N-2:0], scl};
      sda_sr <= {sda_sr[SYNC_N-2:0], sda};
      scl_p  <= scl_s;
      sda_p  <= sda_s;
    end
  end

  assign scl_s     = scl_sr[SYNC_N-1];
  assign sda_s     = sda_sr[SYNC_N-1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/tw_page_store.sv
module tw_page_store
  import tw_eeprom_pkg::*;
#(
  parameter int PAGE_W   = 8,
  parameter int STORE_AW = 11,
  parameter int BUSY_CYC = 500000
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [PAGE_W-1:0]         wr_off,
  input  logic [7:0]                wr_data,
  input  logic                      buf_clr,
  input  logic                      commit_go,
  input  logic [WORD_AW-PAGE_W-1:0] commit_page,
  input  logic [WORD_AW-1:0]        rd_addr,
  output logic [7:0]                rd_data,
  output logic                      busy
);
  localparam int PAGE  = 1 << PAGE_W;
  localparam int DEPTH = 1 << STORE_AW;
  localparam int HOLD  = (BUSY_CYC > PAGE + 1) ? BUSY_CYC : PAGE + 1;
  localparam int CW    = $clog2(HOLD + 1);

  logic [7:0]                pbuf [PAGE];
  logic [PAGE-1:0]           pval;
  logic [7:0]                arr  [DEPTH];
  logic [CW-1:0]             hold_cnt;
  logic [PAGE_W:0]           cidx;
  logic [WORD_AW-PAGE_W-1:0] cpage;
  logic                      sweeping, mem_we;
  logic [WORD_AW-1:0]        sweep_addr;

  function automatic logic [STORE_AW-1:0] slot_of(input logic [WORD_AW-1:0] a);
    return a[STORE_AW-1:0];
  endfunction

  assign busy       = (hold_cnt != '0);
  assign sweeping   = busy && !cidx[PAGE_W];
  assign mem_we     = sweeping && pval[cidx[PAGE_W-1:0]];
  assign sweep_addr = {cpage, cidx[PAGE_W-1:0]};
  assign rd_data    = arr[slot_of(rd_addr)];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_cnt <= '0;
      cidx     <= '0;
      cpage    <= '0;
      pval     <= '0;
    end else begin
      if (commit_go) begin
        hold_cnt <= CW'(HOLD);
        cidx     <= '0;
        cpage    <= commit_page;
      end else if (busy) begin
        hold_cnt <= hold_cnt - 1'b1;
        if (!cidx[PAGE_W]) cidx <= cidx + 1'b1;
      end
      if (busy && cidx[PAGE_W]) pval <= '0;
      else if (!busy && !commit_go && buf_clr) pval <= '0;
      else if (!busy && wr_en) pval[wr_off] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && !busy) pbuf[wr_off] <= wr_data;
    if (mem_we) arr[slot_of(sweep_addr)] <= pbuf[cidx[PAGE_W-1:0]];
  end

  // R2
  commit_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_go |-> !busy);
  // R2
  no_fill_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !busy);
endmodule

// File: rtl/tw_proto_fsm.sv
module tw_proto_fsm
  import tw_eeprom_pkg::*;
#(
  parameter int PAGE_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      scl_rise,
  input  logic                      scl_fall,
  input  logic                      start_det,
  input  logic                      stop_det,
  input  logic                      sda_s,
  input  logic                      sel_strap,
  input  logic                      wr_protect,
  input  logic                      busy,
  input  logic [7:0]                rd_data,
  output logic                      sda_oe,
  output logic [WORD_AW-1:0]        rd_addr,
  output logic                      wr_en,
  output logic [PAGE_W-1:0]         wr_off,
  output logic [7:0]                wr_data,
  output logic                      buf_clr,
  output logic                      commit_go,
  output logic [WORD_AW-PAGE_W-1:0] commit_page
);
  phase_e             phase;
  field_e             field;
  logic [2:0]         bcnt;
  logic [7:0]         sh;
  logic               rnw, a16, pend;
  logic [7:0]         ahi;
  logic [WORD_AW-1:0] cur_addr;
  logic [7:0]         rx_byte;
  logic               sel_ok, clean_stop;

  function automatic logic [WORD_AW-1:0] in_page_next(input logic [WORD_AW-1:0] a);
    logic [PAGE_W-1:0] lo;
    lo = a[PAGE_W-1:0] + 1'b1;
    return {a[WORD_AW-1:PAGE_W], lo};
  endfunction

  function automatic logic [WORD_AW-1:0] seq_next(input logic [WORD_AW-1:0] a);
    return a + 1'b1;
  endfunction

  function automatic field_e field_after(input field_e f);
    case (f)
      FLD_SEL: return FLD_AHI;
      FLD_AHI: return FLD_ALO;
      default: return FLD_DATA;
    endcase
  endfunction

  assign rx_byte    = {sh[6:0], sda_s};
  assign sel_ok     = (rx_byte[7:3] == 5'b10100) && (rx_byte[2] == sel_strap) && !busy;
  assign clean_stop = pend && (phase == PH_RX) && (field == FLD_DATA) && (bcnt == 3'd1);
  assign rd_addr    = cur_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase       <= PH_IDLE;
      field       <= FLD_SEL;
      bcnt        <= '0;
      sh          <= '0;
      rnw         <= 1'b0;
      a16         <= 1'b0;
      pend        <= 1'b0;
      ahi         <= '0;
      cur_addr    <= '0;
      sda_oe      <= 1'b0;
      wr_en       <= 1'b0;
      wr_off      <= '0;
      wr_data     <= '0;
      buf_clr     <= 1'b0;
      commit_go   <= 1'b0;
      commit_page <= '0;
    end else begin
      wr_en     <= 1'b0;
      buf_clr   <= 1'b0;
      commit_go <= 1'b0;
      if (start_det) begin
        phase   <= PH_RX;
        field   <= FLD_SEL;
        bcnt    <= '0;
        sda_oe  <= 1'b0;
        pend    <= 1'b0;
        buf_clr <= 1'b1;
      end else if (stop_det) begin
        phase  <= PH_IDLE;
        sda_oe <= 1'b0;
        pend   <= 1'b0;
        if (clean_stop && !wr_protect) begin
          commit_go   <= 1'b1;
          commit_page <= cur_addr[WORD_AW-1:PAGE_W];
        end else begin
          buf_clr <= 1'b1;
        end
      end else begin
        case (phase)
          PH_RX: if (scl_rise) begin
            sh   <= rx_byte;
            bcnt <= bcnt + 1'b1;
            if (bcnt == 3'd7) begin
              phase <= PH_ACK;
              case (field)
                FLD_SEL: begin
                  if (sel_ok) begin
                    rnw <= rx_byte[0];
                    if (!rx_byte[0]) a16 <= rx_byte[1];
                  end else begin
                    phase <= PH_IDLE;
                  end
                end
                FLD_AHI: ahi <= rx_byte;
                FLD_ALO: cur_addr <= {a16, ahi, rx_byte};
                default: begin
                  wr_en    <= 1'b1;
                  wr_off   <= cur_addr[PAGE_W-1:0];
                  wr_data  <= rx_byte;
                  cur_addr <= in_page_next(cur_addr);
                  pend     <= 1'b1;
                end
              endcase
            end
          end
          PH_ACK: if (scl_fall) begin
            sda_oe <= 1'b1;
            phase  <= PH_ACKH;
          end
          PH_ACKH: if (scl_fall) begin
            bcnt <= '0;
            if (field == FLD_SEL && rnw) begin
              sh     <= rd_data;
              sda_oe <= ~rd_data[7];
              phase  <= PH_TX;
            end else begin
              sda_oe <= 1'b0;
              phase  <= PH_RX;
              field  <= field_after(field);
            end
          end
          PH_TX: if (scl_fall) begin
            if (bcnt == 3'd7) begin
              sda_oe <= 1'b0;
              bcnt   <= '0;
              phase  <= PH_MACK;
            end else begin
              sh     <= {sh[6:0], 1'b0};
              sda_oe <= ~sh[6];
              bcnt   <= bcnt + 1'b1;
            end
          end
          PH_MACK: if (scl_rise) begin
            cur_addr <= seq_next(cur_addr);
            phase    <= sda_s ? PH_IDLE : PH_MACKF;
          end
          PH_MACKF: if (scl_fall) begin
            sh     <= rd_data;
            sda_oe <= ~rd_data[7];
            bcnt   <= '0;
            phase  <= PH_TX;
          end
          default: ;
        endcase
      end
    end
  end

  // R10
  drive_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(scl_fall));
endmodule

// File: rtl/tw_eeprom.sv
module tw_eeprom
  import tw_eeprom_pkg::*;
#(
  parameter int PAGE_W   = 8,
  parameter int STORE_AW = 11,
  parameter int BUSY_CYC = 500000,
  parameter int SYNC_N   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  input  logic sda_in,
  output logic sda_oe,
  input  logic wr_protect,
  input  logic sel_strap
);
  logic                      scl_rise, scl_fall, start_det, stop_det, sda_s;
  logic                      busy, wr_en, buf_clr, commit_go;
  logic [WORD_AW-1:0]        rd_addr;
  logic [7:0]                rd_data, wr_data;
  logic [PAGE_W-1:0]         wr_off;
  logic [WORD_AW-PAGE_W-1:0] commit_page;

  tw_line_sense #(.SYNC_N(SYNC_N)) u_sense (
    .clk, .rst_n, .scl, .sda(sda_in),
    .scl_rise, .scl_fall, .start_det, .stop_det, .sda_s
  );

  tw_proto_fsm #(.PAGE_W(PAGE_W)) u_fsm (
    .clk, .rst_n, .scl_rise, .scl_fall, .start_det, .stop_det, .sda_s,
    .sel_strap, .wr_protect, .busy, .rd_data, .sda_oe, .rd_addr,
    .wr_en, .wr_off, .wr_data, .buf_clr, .commit_go, .commit_page
  );

  tw_page_store #(.PAGE_W(PAGE_W), .STORE_AW(STORE_AW), .BUSY_CYC(BUSY_CYC)) u_store (
    .clk, .rst_n, .wr_en, .wr_off, .wr_data, .buf_clr, .commit_go,
    .commit_page, .rd_addr, .rd_data, .busy
  );

  // R3
  commit_on_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_go |-> $past(stop_det));
  // R5
  protect_no_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(wr_protect, 2));
  // R9
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);
endmodule

// File: tb/tw_eeprom_test.sv
module tw_eeprom_test;
  localparam int PW  = 4;
  localparam int SAW = 9;
  localparam int BC  = 600;
  localparam int Q   = 6;
  localparam int PG  = 1 << PW;
  localparam int DEP = 1 << SAW;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, scl, m_low, wp, strap;
  wire  sda_oe;
  wire  sda_line = ~(m_low | sda_oe);

  tw_eeprom #(.PAGE_W(PW), .STORE_AW(SAW), .BUSY_CYC(BC)) uut (
    .clk, .rst_n, .scl, .sda_in(sda_line), .sda_oe,
    .wr_protect(wp), .sel_strap(strap)
  );

  int checks = 0, errors = 0, cyc = 0;
  logic [7:0]  model [DEP];
  bit          known [DEP];
  logic [16:0] ptr;
  logic [7:0]  wbuf [32];
  logic [7:0]  rbuf [32];

  function automatic int bidx(input logic [16:0] a);
    return int'(a) % DEP;
  endfunction

  function automatic logic [16:0] page_step(input logic [16:0] a);
    logic [PW-1:0] lo;
    lo = a[PW-1:0] + 1'b1;
    return {a[16:PW], lo};
  endfunction

  function automatic logic [7:0] sel(input bit st, input bit a16, input bit rd);
    return {5'b10100, st, a16, rd};
  endfunction

  task automatic chk(input bit ok, input string tag, input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    m_low = 1'b0; tick(Q); scl = 1'b1; tick(Q);
    m_low = 1'b1; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop;
    m_low = 1'b1; tick(Q); scl = 1'b1; tick(Q); m_low = 1'b0; tick(Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      m_low = ~b[i]; tick(Q); scl = 1'b1; tick(2*Q); scl = 1'b0; tick(Q);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    m_low = 1'b0; tick(Q); scl = 1'b1; tick(Q);
    ack = ~sda_line; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] b);
    m_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      scl = 1'b1; tick(Q); b[i] = sda_line; tick(Q); scl = 1'b0; tick(2*Q);
    end
    m_low = mack; tick(Q); scl = 1'b1; tick(2*Q); scl = 1'b0; tick(Q);
    m_low = 1'b0; tick(Q);
  endtask

  task automatic poll_ready(output int tries, output bit first_ack);
    tries = 0; first_ack = 1'b0;
    for (int k = 0; k < 40; k++) begin
      bit a;
      bus_start; send_byte(sel(strap, 1'b0, 1'b0), a); bus_stop;
      if (k == 0) first_ack = a;
      tries++;
      if (a) break;
    end
  endtask

  task automatic send_addr(input logic [16:0] addr, output bit ok);
    bit a;
    ok = 1'b1;
    bus_start;
    send_byte(sel(strap, addr[16], 1'b0), a); ok &= a;
    send_byte(addr[15:8], a); ok &= a;
    send_byte(addr[7:0], a);  ok &= a;
  endtask

  task automatic page_write(input logic [16:0] addr, input int n, output bit ok);
    bit a;
    logic [16:0] p;
    send_addr(addr, ok);
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], a); ok &= a;
    end
    bus_stop;
    p = addr;
    for (int i = 0; i < n; i++) begin
      if (!wp) begin
        model[bidx(p)] = wbuf[i];
        known[bidx(p)] = 1'b1;
      end
      p = page_step(p);
    end
    ptr = p;
  endtask

  task automatic rand_read(input logic [16:0] addr, input int n, output bit ok);
    bit a;
    send_addr(addr, ok);
    bus_start;
    send_byte(sel(strap, 1'b0, 1'b1), a); ok &= a;
    for (int i = 0; i < n; i++) recv_byte(i != n - 1, rbuf[i]);
    bus_stop;
    ptr = addr + 17'(n);
  endtask

  task automatic cur_read(input int n, output bit ok);
    bit a;
    bus_start;
    send_byte(sel(strap, 1'b0, 1'b1), a); ok = a;
    for (int i = 0; i < n; i++) recv_byte(i != n - 1, rbuf[i]);
    bus_stop;
    ptr = ptr + 17'(n);
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000) begin
      checks++; errors++;
      $display("FAIL watchdog R2 actual=%0d expected=%0d", cyc, 0);
      finish_run;
    end
  end

  initial begin
    bit ok, a, fa;
    int tries;
    int unsigned seed;
    logic [16:0] ra;
    int rn;
    seed = 32'd7;
    void'($urandom(seed));
    for (int i = 0; i < DEP; i++) known[i] = 1'b0;
    rst_n = 1'b0; scl = 1'b1; m_low = 1'b0; wp = 1'b0; strap = 1'b1; ptr = '0;
    tick(5); rst_n = 1'b1; tick(5);

    // R10: line released after reset
    chk(sda_oe == 1'b0, "R10 released after reset", int'(sda_oe), 0);

    // R1: wrong strap, wrong prefix, then a matching select
    bus_start; send_byte(sel(1'b0, 1'b0, 1'b0), a); bus_stop;
    chk(!a, "R1 strap mismatch", int'(a), 0);
    bus_start; send_byte(8'hE4, a); bus_stop;
    chk(!a, "R1 prefix mismatch", int'(a), 0);
    bus_start; send_byte(sel(1'b1, 1'b0, 1'b0), a); bus_stop;
    chk(a, "R1 match acknowledged", int'(a), 1);

    // R3 byte write, R2 busy polling
    wbuf[0] = 8'h5A;
    page_write(17'h00000, 1, ok);
    chk(ok, "R3 write bytes acknowledged", int'(ok), 1);
    poll_ready(tries, fa);
    chk(!fa, "R2 first poll refused", int'(fa), 0);
    chk(tries > 1 && tries < 40, "R2 ready after interval", tries, 3);

    // R8: counter resets to zero
    rst_n = 1'b0; tick(3); rst_n = 1'b1; tick(3); ptr = '0;
    cur_read(1, ok);
    chk(rbuf[0] == 8'h5A, "R8 reset counter is zero", int'(rbuf[0]), 8'h5A);

    // R4: page wrap within a page
    for (int i = 0; i < 6; i++) wbuf[i] = 8'h30 + 8'(i);
    page_write(17'h12A0 + 17'(PG - 3), 6, ok);
    poll_ready(tries, fa);
    rand_read(17'h12A0, PG, ok);
    chk(ok, "R6 random read acknowledged", int'(ok), 1);
    chk(rbuf[0] == 8'h33, "R4 wrap offset 0", int'(rbuf[0]), 8'h33);
    chk(rbuf[2] == 8'h35, "R4 wrap offset 2", int'(rbuf[2]), 8'h35);
    chk(rbuf[PG-3] == 8'h30, "R4 first byte at offset", int'(rbuf[PG-3]), 8'h30);

    // R8: current-address read after a random read
    rand_read(17'h12A0 + 17'(PG - 3), 2, ok);
    cur_read(1, ok);
    chk(rbuf[0] == 8'h32, "R8 current address follows last", int'(rbuf[0]), 8'h32);

    // R7: sequential read rolls over the top of the space
    wbuf[0] = 8'hE1; wbuf[1] = 8'hE2;
    page_write(17'h1FFFE, 2, ok); poll_ready(tries, fa);
    wbuf[0] = 8'h17;
    page_write(17'h00001, 1, ok); poll_ready(tries, fa);
    rand_read(17'h1FFFE, 4, ok);
    chk(rbuf[1] == 8'hE2, "R7 byte at 0x1FFFF", int'(rbuf[1]), 8'hE2);
    chk(rbuf[2] == 8'h5A, "R7 rollover to 0", int'(rbuf[2]), 8'h5A);
    chk(rbuf[3] == 8'h17, "R7 continues at 1", int'(rbuf[3]), 8'h17);

    // R5: write protect
    wp = 1'b1;
    wbuf[0] = 8'hC3;
    page_write(17'h00000, 1, ok);
    chk(ok, "R5 protected bytes acknowledged", int'(ok), 1);
    poll_ready(tries, fa);
    chk(fa, "R5 no programming interval", int'(fa), 1);
    wp = 1'b0;
    rand_read(17'h00000, 1, ok);
    chk(rbuf[0] == 8'h5A, "R5 array unchanged", int'(rbuf[0]), 8'h5A);

    // R9: stop inside a byte
    send_addr(17'h00001, ok);
    send_byte(8'h77, a);
    send_bits(8'h33, 4);
    bus_stop;
    chk(sda_oe == 1'b0, "R9 released after stop", int'(sda_oe), 0);
    poll_ready(tries, fa);
    chk(fa, "R9 mid-byte stop no interval", int'(fa), 1);
    rand_read(17'h00001, 1, ok);
    chk(rbuf[0] == 8'h17, "R9 mid-byte stop discards", int'(rbuf[0]), 8'h17);

    // R9: repeated start after data
    send_addr(17'h00000, ok);
    send_byte(8'h99, a);
    bus_start; bus_stop;
    poll_ready(tries, fa);
    chk(fa, "R9 restart no interval", int'(fa), 1);
    rand_read(17'h00000, 1, ok);
    chk(rbuf[0] == 8'h5A, "R9 restart discards", int'(rbuf[0]), 8'h5A);

    // R3 R4 R6 R7: random page writes read back
    for (int it = 0; it < 5; it++) begin
      ra = 17'($urandom) & 17'h1FFFF;
      rn = 1 + int'($urandom % PG);
      for (int i = 0; i < rn; i++) wbuf[i] = 8'($urandom);
      page_write(ra, rn, ok);
      chk(ok, "R3 random write acknowledged", int'(ok), 1);
      poll_ready(tries, fa);
      rand_read(ra, rn, ok);
      for (int i = 0; i < rn; i++) begin
        int ix;
        ix = bidx(ra + 17'(i));
        if (known[ix])
          chk(rbuf[i] == model[ix], "R6 random readback", int'(rbuf[i]), int'(model[ix]));
      end
    end

    finish_run;
  end
endmodule